// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This block sits beside a processor pipeline and watches two address streams: the address of the instruction about to execute, and the address of each data load or store. It holds a small set of programmable instruction breakpoints and data watchpoints. When an enabled breakpoint equals the fetch address, or an armed watchpoint equals a data access of the right kind, it sends a one-cycle debug request toward the exception logic.

A watchpoint match must stop the access before it takes effect. For that reason the unit drives a combinational suppress signal in the same cycle as the access, while the breakpoint and watchpoint request pulses come from registers one cycle later. A sticky per-watchpoint status vector records which entries matched. Software clears a status bit by writing a 1 to it. All programming goes through one synchronous register-write port.

Top module: `dbg_match_unit`

## Requirements
- R1: A watchpoint's 2-bit mode selects its access type. 2'b00 never matches, 2'b01 matches loads only (`mem_we`=0), 2'b10 matches stores only (`mem_we`=1), and 2'b11 matches both.
- R2: A watchpoint whose mode is 2'b00 gives no suppress, no request and no status bit, whatever address is accessed.
- R3: `mem_suppress` is high in the same cycle as a valid access that matches any armed watchpoint, and low otherwise.
- R4: A watchpoint covers one byte. It matches only when every bit of `mem_addr` equals its programmed address.
- R5: A breakpoint matches when `fetch_valid` is high, its enable bit is set, and `fetch_pc[ADDR_W-1:2]` equals its stored word address. `fetch_pc[1:0]` is ignored. `bp_hit` is high for the one cycle after the matching fetch.
- R6: `wp_hit` is raised only when at least one armed watchpoint matched. It is high for exactly one cycle, the cycle after the access, unless it is deferred under R7.
- R7: If a breakpoint and a watchpoint match in the same cycle, `bp_hit` is raised first. `wp_hit` follows in the next cycle that has no new breakpoint match.
- R8: `wp_status[i]` is set when watchpoint i matches and stays set until a clear write has a 1 in bit i. A set and a clear in the same cycle leave the bit set.
- R9: While `rst_n` is low at a clock edge, every breakpoint is disabled, every watchpoint mode is 2'b00, the status is cleared, and both request pulses are low.
- R10: A write (`cfg_we`=1) decodes `cfg_sel[3:2]` as the group and `cfg_sel[1:0]` as the entry. Group 0 is a breakpoint (`cfg_wdata[ADDR_W-1:2]` is the address, `cfg_wdata[0]` the enable). Group 1 is a watchpoint address (all bits). Group 2 is a watchpoint mode (`cfg_wdata[1:0]`). Group 3 is a status clear (`cfg_wdata[NUM_WP-1:0]`, entry ignored). A write changes only the register it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Group in bits 3:2, entry in bits 1:0 |
| cfg_wdata | input | ADDR_W | Write data |
| fetch_valid | input | 1 | Instruction about to execute is valid |
| fetch_pc | input | ADDR_W | Address of that instruction |
| mem_valid | input | 1 | Data access present this cycle |
| mem_we | input | 1 | 1 = store, 0 = load |
| mem_addr | input | ADDR_W | Byte address of the access |
| mem_suppress | output | 1 | Block the current access (combinational) |
| bp_hit | output | 1 | Breakpoint debug request pulse |
| wp_hit | output | 1 | Watchpoint debug request pulse |
| wp_status | output | NUM_WP | Sticky per-watchpoint hit bits |

## Verification
Assertions check several rules on every cycle. A disarmed watchpoint never matches, and a match always agrees with the access direction and its mode. A breakpoint match implies its enable bit. When both kinds match together, the breakpoint wins and the watchpoint request is deferred. Status bits hold until a clear selects them. Only the directed scenarios can show the rest: the exact byte comparison, the ignored low fetch bits, the register decode across groups and entries, the reset contents, and the cycle in which each pulse appears.

// File: rtl/dbg_pkg.sv
// Package dbg_pkg
// Shared encodings for the debug match unit: the watchpoint access mode
// and the register-write group selector.
package dbg_pkg;

    // Watchpoint access mode; bit 0 arms loads, bit 1 arms stores.
    typedef enum logic [1:0] {
        WP_OFF = 2'b00,
        WP_RD  = 2'b01,
        WP_WR  = 2'b10,
        WP_RW  = 2'b11
    } wp_mode_e;

    // Register group carried in the upper two bits of the select.
    typedef enum logic [1:0] {
        GRP_BP  = 2'b00,
        GRP_WPA = 2'b01,
        GRP_WPM = 2'b10,
        GRP_CLR = 2'b11
    } cfg_grp_e;

endpackage

// File: rtl/dbg_cfg_regs.sv
// Module dbg_cfg_regs
// Holds the breakpoint and watchpoint programming registers. It decodes
// the single write port into a group and an entry index.
// Assumes: the index is narrow enough to address every entry; an index
// past the last entry of a group selects nothing. Synchronous active-low reset.
module dbg_cfg_regs #(
    parameter int NUM_BP = 4,
    parameter int NUM_WP = 4,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [IDX_W+1:0]                   cfg_sel,
    input  logic [ADDR_W-1:0]                  cfg_wdata,
    output logic [NUM_BP-1:0][ADDR_W-3:0]      bp_word,
    output logic [NUM_BP-1:0]                  bp_en,
    output logic [NUM_WP-1:0][ADDR_W-1:0]      wp_addr,
    output dbg_pkg::wp_mode_e                  wp_mode [NUM_WP],
    output logic [NUM_WP-1:0]                  clr_mask
);
    import dbg_pkg::*;

    cfg_grp_e         grp;
    logic [IDX_W-1:0] idx;
    logic             unused_wdata_bit;

    // Split the select into group and entry index.
    always_comb begin
        grp = cfg_grp_e'(cfg_sel[IDX_W+1:IDX_W]);
        idx = cfg_sel[IDX_W-1:0];
    end

    assign unused_wdata_bit = cfg_wdata[1];

    // Write-one-to-clear mask for the sticky status; the index is ignored.
    always_comb begin
        clr_mask = '0;
        if (cfg_we && grp == GRP_CLR)
            clr_mask = cfg_wdata[NUM_WP-1:0];
    end

    for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
        // Breakpoint entry b: word address and enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bp_word[b] <= '0;
                bp_en[b]   <= 1'b0;
            end else if (cfg_we && grp == GRP_BP && idx == IDX_W'(b)) begin
                bp_word[b] <= cfg_wdata[ADDR_W-1:2];
                bp_en[b]   <= cfg_wdata[0];
            end
        end
    end

    for (genvar w = 0; w < NUM_WP; w++) begin : g_wp
        // Watchpoint entry w: byte address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                wp_addr[w] <= '0;
            else if (cfg_we && grp == GRP_WPA && idx == IDX_W'(w))
                wp_addr[w] <= cfg_wdata;
        end

        // Watchpoint entry w: access mode.
        always_ff @(posedge clk) begin
            if (!rst_n)
                wp_mode[w] <= WP_OFF;
            else if (cfg_we && grp == GRP_WPM && idx == IDX_W'(w))
                wp_mode[w] <= wp_mode_e'(cfg_wdata[1:0]);
        end

        // R9: the cycle after reset every mode is disarmed.
        p_mode_reset_r9: assert property (@(posedge clk)
            !rst_n |=> (wp_mode[w] == WP_OFF))
            else $error("watchpoint mode not cleared by reset");
    end

endmodule

// File: rtl/dbg_bp_cmp.sv
// Module dbg_bp_cmp
// One breakpoint comparator. It compares the word address of the
// instruction about to execute with a stored word address.
// Assumes: instructions are word aligned, so the two low PC bits are dropped upstream.
module dbg_bp_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-3:0] pc_word,
    input  logic              en,
    input  logic [ADDR_W-3:0] bp_word,
    output logic              match
);

    // Exact word equality, gated by the enable and a valid fetch.
    always_comb begin
        match = fetch_valid && en && (pc_word == bp_word);
    end

    // R5: a breakpoint only fires while it is enabled and a fetch is present.
    p_bp_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (en && fetch_valid))
        else $error("breakpoint matched while disabled");

endmodule

// File: rtl/dbg_wp_cmp.sv
// Module dbg_wp_cmp
// One watchpoint comparator. It matches a single byte address against the
// data access, qualified by the entry's access-type mode.
// Assumes: one access per cycle; mem_we gives its direction.
module dbg_wp_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_valid,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [ADDR_W-1:0] wp_addr,
    input  dbg_pkg::wp_mode_e mode,
    output logic              match
);
    import dbg_pkg::*;

    logic kind_ok;

    // Decide from the mode whether this access direction is armed.
    always_comb begin
        unique case (mode)
            WP_OFF:  kind_ok = 1'b0;
            WP_RD:   kind_ok = !mem_we;
            WP_WR:   kind_ok = mem_we;
            WP_RW:   kind_ok = 1'b1;
            default: kind_ok = 1'b0;
        endcase
    end

    // Byte-exact address compare on a valid, armed access.
    always_comb begin
        match = mem_valid && kind_ok && (mem_addr == wp_addr);
    end

    // R2: a disarmed entry never matches.
    p_off_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WP_OFF) |-> !match)
        else $error("disarmed watchpoint matched");

    // R1: a store match needs the store bit of the mode, a load match the load bit.
    p_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (mem_we ? mode[1] : mode[0]))
        else $error("watchpoint matched wrong access type");

endmodule

// File: rtl/dbg_hit_ctrl.sv
// Module dbg_hit_ctrl
// Turns comparator matches into registered debug request pulses. When
// both kinds match together, the breakpoint is reported first and the
// watchpoint is held one more cycle. Also keeps the sticky watchpoint status.
// Assumes: matches are valid for one cycle each. Synchronous active-low reset.
module dbg_hit_ctrl #(
    parameter int NUM_BP = 4,
    parameter int NUM_WP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_BP-1:0] bp_match,
    input  logic [NUM_WP-1:0] wp_match,
    input  logic [NUM_WP-1:0] clr_mask,
    output logic              bp_hit,
    output logic              wp_hit,
    output logic [NUM_WP-1:0] wp_status
);

    logic bp_any;
    logic wp_any;
    logic wp_pend;
    logic wp_req;

    // Collapse the per-entry matches and merge any deferred watchpoint.
    always_comb begin
        bp_any = |bp_match;
        wp_any = |wp_match;
        wp_req = wp_any || wp_pend;
    end

    // Request pulses, with breakpoint priority and watchpoint deferral.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_hit  <= 1'b0;
            wp_hit  <= 1'b0;
            wp_pend <= 1'b0;
        end else begin
            bp_hit  <= bp_any;
            wp_hit  <= wp_req && !bp_any;
            wp_pend <= wp_req && bp_any;
        end
    end

    // Sticky status; a new match wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wp_status <= '0;
        else
            wp_status <= (wp_status & ~clr_mask) | wp_match;
    end

    // R7: a coincident pair reports the breakpoint alone first.
    p_bp_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_any && wp_any) |=> (bp_hit && !wp_hit))
        else $error("watchpoint reported ahead of breakpoint");

    // R7: a deferred watchpoint is released once no breakpoint competes.
    p_defer_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_pend && !bp_any) |=> wp_hit)
        else $error("deferred watchpoint request lost");

    // R6: a watchpoint request always traces back to a match or a deferral.
    p_wp_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wp_hit) |-> ($past(wp_any) || $past(wp_pend)))
        else $error("watchpoint request without match");

    for (genvar w = 0; w < NUM_WP; w++) begin : g_sticky
        // R8: a status bit holds unless a clear selects it.
        p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wp_status[w] && !clr_mask[w]) |=> wp_status[w])
            else $error("status bit dropped without clear");
    end

endmodule

// File: rtl/dbg_match_unit.sv
// Module dbg_match_unit (top)
// Debug breakpoint and watchpoint unit. It compares fetch and data-access
// addresses with the programmed entries. It suppresses a matching access in
// the same cycle and raises one-cycle debug request pulses one cycle later.
// Assumes: at most one fetch and one data access per cycle; synchronous active-low reset.
module dbg_match_unit #(
    parameter int NUM_BP = 4,
    parameter int NUM_WP = 4,
    parameter int ADDR_W = 32,
    localparam int IDX_RAW = (NUM_BP > NUM_WP) ? $clog2(NUM_BP) : $clog2(NUM_WP),
    localparam int IDX_W   = (IDX_RAW < 1) ? 1 : IDX_RAW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W+1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              mem_valid,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              mem_suppress,
    output logic              bp_hit,
    output logic              wp_hit,
    output logic [NUM_WP-1:0] wp_status
);
    import dbg_pkg::*;

    logic [NUM_BP-1:0][ADDR_W-3:0] bp_word;
    logic [NUM_BP-1:0]             bp_en;
    logic [NUM_WP-1:0][ADDR_W-1:0] wp_addr;
    wp_mode_e                      wp_mode [NUM_WP];
    logic [NUM_WP-1:0]             clr_mask;
    logic [NUM_BP-1:0]             bp_match;
    logic [NUM_WP-1:0]             wp_match;
    logic [1:0]                    unused_pc_low;

    assign unused_pc_low = fetch_pc[1:0];

    dbg_cfg_regs #(
        .NUM_BP (NUM_BP),
        .NUM_WP (NUM_WP),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .bp_word   (bp_word),
        .bp_en     (bp_en),
        .wp_addr   (wp_addr),
        .wp_mode   (wp_mode),
        .clr_mask  (clr_mask)
    );

    for (genvar b = 0; b < NUM_BP; b++) begin : g_bpc
        dbg_bp_cmp #(.ADDR_W(ADDR_W)) i_bp (
            .clk         (clk),
            .rst_n       (rst_n),
            .fetch_valid (fetch_valid),
            .pc_word     (fetch_pc[ADDR_W-1:2]),
            .en          (bp_en[b]),
            .bp_word     (bp_word[b]),
            .match       (bp_match[b])
        );
    end

    for (genvar w = 0; w < NUM_WP; w++) begin : g_wpc
        dbg_wp_cmp #(.ADDR_W(ADDR_W)) i_wp (
            .clk       (clk),
            .rst_n     (rst_n),
            .mem_valid (mem_valid),
            .mem_we    (mem_we),
            .mem_addr  (mem_addr),
            .wp_addr   (wp_addr[w]),
            .mode      (wp_mode[w]),
            .match     (wp_match[w])
        );
    end

    // Suppress the access in its own cycle, before it can commit.
    always_comb begin
        mem_suppress = |wp_match;
    end

    dbg_hit_ctrl #(
        .NUM_BP (NUM_BP),
        .NUM_WP (NUM_WP)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bp_match  (bp_match),
        .wp_match  (wp_match),
        .clr_mask  (clr_mask),
        .bp_hit    (bp_hit),
        .wp_hit    (wp_hit),
        .wp_status (wp_status)
    );

    // R3: a suppressed access is always followed by a status bit.
    p_suppress_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_suppress |=> (wp_status != '0))
        else $error("suppressed access left no status");

endmodule

// File: tb/test_dbg_match_unit.sv
// Directed bench for dbg_match_unit. Inputs change on the falling edge.
// Combinational outputs are sampled 1 ns after a change; registered
// outputs are sampled on the falling edge after the clock edge.
module test_dbg_match_unit;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          mem_valid = 1'b0;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic          mem_suppress;
    logic          bp_hit;
    logic          wp_hit;
    logic [3:0]    wp_status;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    dbg_match_unit i_dbg_match_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .fetch_valid  (fetch_valid),
        .fetch_pc     (fetch_pc),
        .mem_valid    (mem_valid),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_suppress (mem_suppress),
        .bp_hit       (bp_hit),
        .wp_hit       (wp_hit),
        .wp_status    (wp_status)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] grp, input logic [1:0] idx,
                             input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = {grp, idx}; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    endtask

    // One data access; checks suppress now and the request pulse next edge.
    task automatic access(input string req, input logic we, input logic [31:0] a,
                          input logic exp_hit);
        mem_valid = 1'b1; mem_we = we; mem_addr = a;
        #1 check(req, "mem_suppress", 32'(mem_suppress), 32'(exp_hit));
        @(negedge clk);
        mem_valid = 1'b0; mem_we = 1'b0; mem_addr = '0;
        check(req, "wp_hit", 32'(wp_hit), 32'(exp_hit));
        @(negedge clk);
        check(req, "wp_hit one cycle", 32'(wp_hit), 32'h0);
    endtask

    task automatic fetch(input string req, input logic [31:0] pc, input logic exp_hit);
        fetch_valid = 1'b1; fetch_pc = pc;
        @(negedge clk);
        fetch_valid = 1'b0; fetch_pc = '0;
        check(req, "bp_hit", 32'(bp_hit), 32'(exp_hit));
        @(negedge clk);
        check(req, "bp_hit one cycle", 32'(bp_hit), 32'h0);
    endtask

    task automatic t_reset;  // R9 and R2
        check("R9", "bp_hit", 32'(bp_hit), 32'h0);
        check("R9", "wp_hit", 32'(wp_hit), 32'h0);
        check("R9", "wp_status", 32'(wp_status), 32'h0);
        access("R9", 1'b0, 32'h0, 1'b0);   // all entries disarmed, address 0
        access("R9", 1'b1, 32'h0, 1'b0);
        fetch("R9", 32'h0, 1'b0);          // breakpoints disabled
    endtask

    task automatic t_breakpoint;  // R5, R10
        cfg_write(2'd0, 2'd0, 32'h0000_0101);  // address 0x100, enabled
        fetch("R5", 32'h100, 1'b1);
        fetch("R5", 32'h103, 1'b1);            // low bits ignored
        fetch("R5", 32'h104, 1'b0);
        cfg_write(2'd0, 2'd0, 32'h0000_0100);  // disable
        fetch("R5", 32'h100, 1'b0);
        cfg_write(2'd0, 2'd2, 32'h0000_0801);  // entry 2 only
        fetch("R10", 32'h800, 1'b1);
        fetch("R10", 32'h100, 1'b0);
    endtask

    task automatic t_modes;  // R1, R4, R2, R3
        cfg_write(2'd1, 2'd0, 32'h0000_0200);
        cfg_write(2'd2, 2'd0, 32'h1);          // loads only
        access("R1", 1'b0, 32'h200, 1'b1);
        access("R1", 1'b1, 32'h200, 1'b0);
        cfg_write(2'd2, 2'd0, 32'h2);          // stores only
        access("R1", 1'b1, 32'h200, 1'b1);
        access("R1", 1'b0, 32'h200, 1'b0);
        cfg_write(2'd2, 2'd0, 32'h3);          // both
        access("R3", 1'b0, 32'h200, 1'b1);
        access("R3", 1'b1, 32'h200, 1'b1);
        access("R4", 1'b0, 32'h201, 1'b0);
        access("R4", 1'b1, 32'h1FF, 1'b0);
        access("R4", 1'b0, 32'h8000_0200, 1'b0);
        cfg_write(2'd3, 2'd0, 32'hF);
        cfg_write(2'd2, 2'd0, 32'h0);          // disarm
        access("R2", 1'b0, 32'h200, 1'b0);
        access("R2", 1'b1, 32'h200, 1'b0);
        check("R2", "wp_status after disarmed accesses", 32'(wp_status), 32'h0);
    endtask

    task automatic t_sticky;  // R8, R10
        cfg_write(2'd1, 2'd3, 32'h0000_0400);
        cfg_write(2'd2, 2'd3, 32'h3);
        access("R8", 1'b1, 32'h400, 1'b1);
        check("R8", "status set", 32'(wp_status), 32'h8);
        cfg_write(2'd3, 2'd3, 32'h7);          // clears other bits only
        check("R8", "status kept by zero bit", 32'(wp_status), 32'h8);
        // Set and clear in one cycle: set wins.
        cfg_we = 1'b1; cfg_sel = 4'hC; cfg_wdata = 32'h8;
        mem_valid = 1'b1; mem_we = 1'b0; mem_addr = 32'h400;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        mem_valid = 1'b0; mem_addr = '0;
        check("R8", "set wins over clear", 32'(wp_status), 32'h8);
        @(negedge clk);
        cfg_write(2'd3, 2'd0, 32'h8);
        check("R8", "status cleared", 32'(wp_status), 32'h0);
    endtask

    task automatic t_priority;  // R7, R6
        cfg_write(2'd0, 2'd1, 32'h0000_0501);
        cfg_write(2'd1, 2'd1, 32'h0000_0600);
        cfg_write(2'd2, 2'd1, 32'h3);
        fetch_valid = 1'b1; fetch_pc = 32'h500;
        mem_valid = 1'b1; mem_we = 1'b1; mem_addr = 32'h600;
        #1 check("R7", "suppress on coincident", 32'(mem_suppress), 32'h1);
        @(negedge clk);
        fetch_valid = 1'b0; fetch_pc = '0;
        mem_valid = 1'b0; mem_we = 1'b0; mem_addr = '0;
        check("R7", "bp first", 32'(bp_hit), 32'h1);
        check("R7", "wp held", 32'(wp_hit), 32'h0);
        @(negedge clk);
        check("R7", "bp done", 32'(bp_hit), 32'h0);
        check("R7", "wp follows", 32'(wp_hit), 32'h1);
        @(negedge clk);
        check("R6", "wp single pulse", 32'(wp_hit), 32'h0);
        check("R8", "status entry 1", 32'(wp_status), 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_breakpoint();
        t_modes();
        t_sticky();
        t_priority();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule